// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken by running two direction predictors side by side. They look up their tables at the same time. The first is a global-history predictor. It combines a word-aligned slice of the program counter, through XOR, with a shift register that records the resolved outcomes of the most recent branches. The second is a bimodal predictor, indexed by the branch address alone. A third table of per-branch chooser counters decides which of the two answers becomes the final direction.

Fetch presents a PC with a valid strobe. One clock later the block returns:
- the final direction,
- both component directions,
- the chooser's pick.

When the branch resolves, the back end returns four things on the update port:
- the PC,
- the real outcome,
- the two component directions that were captured at predict time.

The block then trains all three tables and shifts the outcome into the history. History changes only on updates, never speculatively.

Top module: `tourney_bp`

## Requirements
- R1: After reset the history register is zero. Every component counter holds 1 (weakly not-taken) and every chooser counter holds 1 (weakly bimodal). A prediction made before any update therefore returns 0 on pred_taken_o, pred_glob_o, pred_bim_o and pred_use_glob_o.
- R2: pred_valid_o is high in exactly the cycle after a cycle with pred_valid_i high. The prediction outputs belong to that PC.
- R3: The bimodal table index is PC bits [BIDX_W+1:2]. PCs that differ only above bit BIDX_W+1 share one bimodal counter.
- R4: The global table index is PC bits [GIDX_W+1:2] XOR the history register, with the history zero-extended into the low bits.
- R5: Each update shifts the resolved outcome into history bit 0, and the older bits move one place up. History does not change without an update.
- R6: Each counter is 2 bits wide, saturates at 0 and 3, and predicts taken when its value is 2 or more. Every update steps both component counters toward the outcome, whichever component was chosen.
- R7: A chooser counter changes only on an update where upd_glob_i and upd_bim_i differ. It steps up when the global answer matched the outcome and down otherwise.
- R8: pred_use_glob_o is 1 when the chooser counter is 2 or more. pred_taken_o equals pred_glob_o when pred_use_glob_o is 1 and pred_bim_o otherwise.
- R9: When a prediction and an update touch the same entry in one cycle, the prediction returns the value from before that update.
- R10: While pred_valid_i is low, the prediction outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| pred_valid_i | input | 1 | look up a prediction this cycle |
| pred_pc_i | input | PC_W | PC of the fetched branch |
| pred_valid_o | output | 1 | prediction outputs are new this cycle |
| pred_taken_o | output | 1 | final direction |
| pred_glob_o | output | 1 | global-history component direction |
| pred_bim_o | output | 1 | bimodal component direction |
| pred_use_glob_o | output | 1 | chooser picked the global component |
| upd_valid_i | input | 1 | a resolved branch is presented |
| upd_pc_i | input | PC_W | PC of the resolved branch |
| upd_taken_i | input | 1 | resolved outcome |
| upd_glob_i | input | 1 | global direction captured at predict time |
| upd_bim_i | input | 1 | bimodal direction captured at predict time |

## Verification
The hardest case to reach from the ports is a prediction in the same cycle as an update to the same entry. The global entry moves with history, so it is hard to hit on purpose. The stimulus handles it in two ways. It drives one PC on both ports in a single cycle, where the bimodal entry is certain to collide. It also runs a long random phase over a handful of PCs with a short history, so that global and chooser entries collide often. Chooser training needs the captured component answers to disagree. The directed steps therefore feed chosen disagreeing pairs and then check the chooser's pick as it flips.

// File: rtl/bp_pkg.sv
package bp_pkg;
  typedef logic [1:0] ctr2_t;

  localparam ctr2_t CTR_MIN = 2'd0;
  localparam ctr2_t CTR_MAX = 2'd3;
  localparam ctr2_t CTR_WEAK_LOW = 2'd1;

  function automatic ctr2_t ctr_step(input ctr2_t c, input logic up);
    ctr2_t r;
    r = c;
    if (up && c != CTR_MAX) r = c + 2'd1;
    else if (!up && c != CTR_MIN) r = c - 2'd1;
    return r;
  endfunction
endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import bp_pkg::*;
#(
  parameter int    IDX_W = 9,
  parameter ctr2_t INIT  = CTR_WEAK_LOW
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr2_t            rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_up
);
  localparam int DEPTH = 1 << IDX_W;

  ctr2_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= INIT;
      rd_ctr <= INIT;
    end else begin
      if (rd_en) rd_ctr <= mem[rd_idx];
      if (wr_en) mem[wr_idx] <= ctr_step(mem[wr_idx], wr_up);
    end
  end

  // R6: saturation at both ends, single steps otherwise
  p_sat_top_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_up && mem[wr_idx] == CTR_MAX) |=> mem[$past(wr_idx)] == CTR_MAX);
  p_sat_bot_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !wr_up && mem[wr_idx] == CTR_MIN) |=> mem[$past(wr_idx)] == CTR_MIN);
  p_step_up_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_up && mem[wr_idx] != CTR_MAX) |=>
      mem[$past(wr_idx)] == $past(mem[wr_idx]) + 2'd1);
endmodule

// File: rtl/bp_hist.sv
module bp_hist #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] hist
);
  generate
    if (W == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else if (shift_en) hist <= bit_in;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) hist <= '0;
        else if (shift_en) hist <= {hist[W-2:0], bit_in};
      end
    end
  endgenerate

  // R5: history is frozen when no update arrives
  p_hist_hold_r5: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(hist));
  p_hist_new_r5: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> hist[0] == $past(bit_in));
endmodule

// File: rtl/tourney_bp.sv
module tourney_bp
  import bp_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int HIST_W = 8,
  parameter int GIDX_W = 9,
  parameter int BIDX_W = 9,
  parameter int SIDX_W = 9
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pred_valid_i,
  input  logic [PC_W-1:0] pred_pc_i,
  output logic            pred_valid_o,
  output logic            pred_taken_o,
  output logic            pred_glob_o,
  output logic            pred_bim_o,
  output logic            pred_use_glob_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic            upd_glob_i,
  input  logic            upd_bim_i
);
  localparam int PC_LSB = 2;

  logic [HIST_W-1:0] ghist;
  logic [GIDX_W-1:0] hist_ext;
  logic [GIDX_W-1:0] g_rd_idx, g_wr_idx;
  logic [BIDX_W-1:0] b_rd_idx, b_wr_idx;
  logic [SIDX_W-1:0] s_rd_idx, s_wr_idx;
  ctr2_t g_ctr, b_ctr, s_ctr;
  logic  sel_train, sel_up;

  generate
    if (GIDX_W > HIST_W) begin : g_pad
      assign hist_ext = {{(GIDX_W-HIST_W){1'b0}}, ghist};
    end else begin : g_full
      assign hist_ext = ghist[GIDX_W-1:0];
    end
  endgenerate

  assign g_rd_idx = pred_pc_i[GIDX_W+PC_LSB-1:PC_LSB] ^ hist_ext;
  assign g_wr_idx = upd_pc_i[GIDX_W+PC_LSB-1:PC_LSB] ^ hist_ext;
  assign b_rd_idx = pred_pc_i[BIDX_W+PC_LSB-1:PC_LSB];
  assign b_wr_idx = upd_pc_i[BIDX_W+PC_LSB-1:PC_LSB];
  assign s_rd_idx = pred_pc_i[SIDX_W+PC_LSB-1:PC_LSB];
  assign s_wr_idx = upd_pc_i[SIDX_W+PC_LSB-1:PC_LSB];

  assign sel_train = upd_valid_i && (upd_glob_i != upd_bim_i);
  assign sel_up    = (upd_glob_i == upd_taken_i);

  bp_hist #(.W(HIST_W)) u_hist (
    .clk(clk), .rst(rst), .shift_en(upd_valid_i), .bit_in(upd_taken_i), .hist(ghist)
  );

  bp_ctr_table #(.IDX_W(GIDX_W), .INIT(CTR_WEAK_LOW)) u_glob (
    .clk(clk), .rst(rst),
    .rd_en(pred_valid_i), .rd_idx(g_rd_idx), .rd_ctr(g_ctr),
    .wr_en(upd_valid_i), .wr_idx(g_wr_idx), .wr_up(upd_taken_i)
  );

  bp_ctr_table #(.IDX_W(BIDX_W), .INIT(CTR_WEAK_LOW)) u_bim (
    .clk(clk), .rst(rst),
    .rd_en(pred_valid_i), .rd_idx(b_rd_idx), .rd_ctr(b_ctr),
    .wr_en(upd_valid_i), .wr_idx(b_wr_idx), .wr_up(upd_taken_i)
  );

  bp_ctr_table #(.IDX_W(SIDX_W), .INIT(CTR_WEAK_LOW)) u_sel (
    .clk(clk), .rst(rst),
    .rd_en(pred_valid_i), .rd_idx(s_rd_idx), .rd_ctr(s_ctr),
    .wr_en(sel_train), .wr_idx(s_wr_idx), .wr_up(sel_up)
  );

  always_ff @(posedge clk) begin
    if (rst) pred_valid_o <= 1'b0;
    else     pred_valid_o <= pred_valid_i;
  end

  assign pred_glob_o     = g_ctr[1];
  assign pred_bim_o      = b_ctr[1];
  assign pred_use_glob_o = s_ctr[1];
  assign pred_taken_o    = s_ctr[1] ? g_ctr[1] : b_ctr[1];

  // R2: one-cycle prediction latency
  p_valid_lat_r2: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> pred_valid_o == $past(pred_valid_i));
  // R10: no lookup, no change at the prediction outputs
  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && !$past(pred_valid_i)) |->
      ($stable(pred_glob_o) && $stable(pred_bim_o) && $stable(pred_use_glob_o)));
endmodule

// File: tb/sim_tourney_bp.sv
`timescale 1ns/1ps
module sim_tourney_bp;
  localparam int PW = 32, HW = 8, GW = 9, BW = 9, SW = 9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pred_valid_i = 1'b0;
  logic [PW-1:0] pred_pc_i = '0;
  logic pred_valid_o, pred_taken_o, pred_glob_o, pred_bim_o, pred_use_glob_o;
  logic upd_valid_i = 1'b0;
  logic [PW-1:0] upd_pc_i = '0;
  logic upd_taken_i = 1'b0, upd_glob_i = 1'b0, upd_bim_i = 1'b0;

  int checks = 0, errors = 0;
  bit model_on = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  tourney_bp #(.PC_W(PW), .HIST_W(HW), .GIDX_W(GW), .BIDX_W(BW), .SIDX_W(SW)) u0 (
    .clk(clk), .rst(rst),
    .pred_valid_i(pred_valid_i), .pred_pc_i(pred_pc_i),
    .pred_valid_o(pred_valid_o), .pred_taken_o(pred_taken_o),
    .pred_glob_o(pred_glob_o), .pred_bim_o(pred_bim_o),
    .pred_use_glob_o(pred_use_glob_o),
    .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i), .upd_taken_i(upd_taken_i),
    .upd_glob_i(upd_glob_i), .upd_bim_i(upd_bim_i)
  );

  // behavioural reference
  int gm [1<<GW];
  int bm [1<<BW];
  int sm [1<<SW];
  int ghr;
  bit e_v, e_t, e_g, e_b, e_s;

  function automatic int sat(int c, bit up);
    if (up) return (c < 3) ? c + 1 : 3;
    return (c > 0) ? c - 1 : 0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      foreach (gm[i]) gm[i] = 1;
      foreach (bm[i]) bm[i] = 1;
      foreach (sm[i]) sm[i] = 1;
      ghr = 0;
      e_v = 0; e_t = 0; e_g = 0; e_b = 0; e_s = 0;
    end else begin
      int pw, uw;
      pw = int'(pred_pc_i >> 2);
      uw = int'(upd_pc_i >> 2);
      e_v = pred_valid_i;
      if (pred_valid_i) begin
        e_g = gm[(pw % (1<<GW)) ^ ghr] >= 2;
        e_b = bm[pw % (1<<BW)] >= 2;
        e_s = sm[pw % (1<<SW)] >= 2;
        e_t = e_s ? e_g : e_b;
      end
      if (upd_valid_i) begin
        int gi;
        gi = (uw % (1<<GW)) ^ ghr;
        gm[gi] = sat(gm[gi], upd_taken_i);
        bm[uw % (1<<BW)] = sat(bm[uw % (1<<BW)], upd_taken_i);
        if (upd_glob_i != upd_bim_i)
          sm[uw % (1<<SW)] = sat(sm[uw % (1<<SW)], upd_glob_i == upd_taken_i);
        ghr = ((ghr << 1) | int'(upd_taken_i)) % (1<<HW);
      end
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on && !rst) begin
      chk("R2 valid vs model", pred_valid_o, e_v);
      chk("R6 global dir vs model", pred_glob_o, e_g);
      chk("R6 bimodal dir vs model", pred_bim_o, e_b);
      chk("R7 chooser vs model", pred_use_glob_o, e_s);
      chk("R8 final vs model", pred_taken_o, e_t);
    end
  end

  task automatic predict(input logic [PW-1:0] pc);
    @(negedge clk);
    pred_valid_i = 1'b1; pred_pc_i = pc;
    @(negedge clk);
    pred_valid_i = 1'b0;
  endtask

  task automatic update(input logic [PW-1:0] pc, input logic t, input logic g, input logic b);
    @(negedge clk);
    upd_valid_i = 1'b1; upd_pc_i = pc; upd_taken_i = t; upd_glob_i = g; upd_bim_i = b;
    @(negedge clk);
    upd_valid_i = 1'b0;
  endtask

  task automatic both(input logic [PW-1:0] pc, input logic t, input logic g, input logic b);
    @(negedge clk);
    pred_valid_i = 1'b1; pred_pc_i = pc;
    upd_valid_i = 1'b1; upd_pc_i = pc; upd_taken_i = t; upd_glob_i = g; upd_bim_i = b;
    @(negedge clk);
    pred_valid_i = 1'b0; upd_valid_i = 1'b0;
  endtask

  localparam logic [PW-1:0] PA = 32'h0000_0100; // index 0x40
  localparam logic [PW-1:0] PB = 32'h0000_0104; // index 0x41
  localparam logic [PW-1:0] PC_ALIAS = 32'h0000_0900; // same low index as PA

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_on = 1'b1;

    predict(PA);
    chk("R1 taken after reset", pred_taken_o, 1'b0);
    chk("R1 glob after reset", pred_glob_o, 1'b0);
    chk("R1 bim after reset", pred_bim_o, 1'b0);
    chk("R1 chooser after reset", pred_use_glob_o, 1'b0);
    chk("R2 valid after lookup", pred_valid_o, 1'b1);

    update(PA, 1'b1, 1'b0, 1'b0);       // history becomes 1
    predict(PA);
    chk("R3 bimodal trained", pred_bim_o, 1'b1);
    chk("R4 R5 global index moved by history", pred_glob_o, 1'b0);
    chk("R8 final follows bimodal", pred_taken_o, 1'b1);
    predict(PB);
    chk("R4 xor hits trained global entry", pred_glob_o, 1'b1);
    chk("R3 neighbour bimodal untouched", pred_bim_o, 1'b0);
    predict(PC_ALIAS);
    chk("R3 alias above index bits", pred_bim_o, 1'b1);

    update(PB, 1'b1, 1'b1, 1'b0);       // global right: chooser 1->2
    predict(PB);
    chk("R7 chooser moved to global", pred_use_glob_o, 1'b1);
    chk("R8 final follows global", pred_taken_o, 1'b0);
    update(PB, 1'b0, 1'b1, 1'b1);       // agree: chooser stays
    predict(PB);
    chk("R7 chooser unchanged on agreement", pred_use_glob_o, 1'b1);

    both(PA, 1'b0, 1'b0, 1'b0);         // bimodal PA 2->1 at same edge
    chk("R9 same-cycle read sees old value", pred_bim_o, 1'b1);
    predict(PA);
    chk("R9 next read sees new value", pred_bim_o, 1'b0);

    for (int k = 0; k < 5; k++) update(PB, 1'b1, 1'b0, 1'b0);
    update(PB, 1'b0, 1'b0, 1'b0);
    update(PB, 1'b0, 1'b0, 1'b0);
    predict(PB);
    chk("R6 saturated then two decrements", pred_bim_o, 1'b0);

    predict(PA);
    begin
      logic hg, hb, hs, ht;
      hg = pred_glob_o; hb = pred_bim_o; hs = pred_use_glob_o; ht = pred_taken_o;
      pred_pc_i = PB;
      update(PB, 1'b1, 1'b1, 1'b0);
      repeat (2) @(negedge clk);
      chk("R10 glob held", pred_glob_o, hg);
      chk("R10 bim held", pred_bim_o, hb);
      chk("R10 chooser held", pred_use_glob_o, hs);
      chk("R10 final held", pred_taken_o, ht);
      chk("R2 valid low when idle", pred_valid_o, 1'b0);
    end

    for (int c = 0; c < 4000; c++) begin
      @(negedge clk);
      pred_valid_i = $urandom_range(0, 3) != 0;
      pred_pc_i = {24'h0, 6'($urandom_range(0, 7)), 2'b00};
      upd_valid_i = $urandom_range(0, 2) != 0;
      upd_pc_i = {24'h0, 6'($urandom_range(0, 7)), 2'b00};
      upd_taken_i = $urandom_range(0, 3) != 0;
      upd_glob_i = 1'($urandom_range(0, 1));
      upd_bim_i = 1'($urandom_range(0, 1));
    end
    @(negedge clk);
    pred_valid_i = 1'b0; upd_valid_i = 1'b0;
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule